// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Controller

This block keeps one rank of DDR SDRAM refreshed and moves it in and out of its clock-enable driven low-power states. A free-running interval timer adds one owed refresh each period. When the command arbiter grants the bus, the controller closes any open rows with a precharge-all. It waits the precharge time, issues an auto refresh, and keeps the bus for the refresh cycle time. If the arbiter keeps the bus for a long burst, refreshes are postponed and counted. When eight are owed, the controller raises a force flag, takes the bus back and issues a refresh without waiting for a grant.

On a sleep request with the arbiter idle, the controller drops both clock enables. It enters either power-down, with no command, or self refresh, with a refresh command issued on the same edge that clock enable falls. Each low phase lasts at least a minimum number of cycles. On exit from power-down it waits a short exit delay. It then issues every refresh that fell due while asleep, back to back, and only after that hands the bus back. On exit from self refresh it waits a short delay before other commands and a much longer one before reads. The arbiter uses `cmd_ok` and `rd_ok` to decide what it may send.

States: IDLE (arbiter owns the bus), PRE (precharge-all), TRP (precharge wait), REF (auto refresh), TRFC (refresh wait), SRE (self-refresh entry), SR (self refresh), PD (power-down), XP (power-down exit wait), XSR (self-refresh exit wait). Transitions:
- IDLE→PRE or IDLE→REF on an owed refresh, depending on whether a bank is open.
- IDLE→PRE or IDLE→SRE on a self-refresh request, depending on whether a bank is open.
- IDLE→PD on a power-down request.
- PRE→TRP, and TRP→REF or TRP→SRE by goal.
- REF→TRFC, and TRFC→IDLE. TRFC→REF while catching up.
- SRE→SR, SR→XSR on wake, and XSR→IDLE.
- PD→XP on wake or when the debt is full, and XP→IDLE.

Top module: `sdram_refresh_pm`

## Requirements
- R1: After reset, both clock enables are high, `cmd` is NOP (0), `addr10` is low, `cmd_ok` and `rd_ok` are high, and `ref_force` is low.
- R2: Every REF_INTERVAL cycles, outside self refresh, one refresh becomes owed. An owed refresh is issued as `cmd`=2 (REF) with clock enables high, when `arb_gnt` is high and no bank is open.
- R3: If `banks_open` is high when a refresh or a self-refresh entry starts, a precharge-all (`cmd`=1) is issued first with `addr10` high. The next command follows exactly T_RP cycles later.
- R4: After a REF, `cmd_ok` stays low and no command issues for T_RFC cycles. `cmd_ok` rises exactly T_RFC cycles after the REF.
- R5: With `arb_gnt` low, refreshes are postponed. When MAX_DEBT are owed, `ref_force` is high and `cmd_ok` is low, and a REF issues in the following cycle regardless of `arb_gnt`.
- R6: A self-refresh request (`sleep_req` with `sleep_sr`=1, `arb_gnt` high) issues REF with both clock enables low. The clock enables stay low, with no command, until `wake_req`.
- R7: After self-refresh exit (clock enables rise), `cmd_ok` rises T_XSNR cycles later and `rd_ok` rises T_XSRD cycles later.
- R8: A power-down request (`sleep_sr`=0) drops both clock enables with `cmd` NOP. A command may follow T_XP cycles after the clock enables rise again.
- R9: The interval timer keeps running in power-down. On exit, all owed refreshes issue back to back, T_RFC cycles apart, while `cmd_ok` stays low.
- R10: If the owed count reaches MAX_DEBT during power-down, the controller leaves power-down without `wake_req`.
- R11: All clock-enable outputs always carry the same level.
- R12: No refresh is owed for self-refresh time. The first REF after exit comes REF_INTERVAL+1 cycles after the clock enables rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_gnt | input | 1 | Arbiter is idle and grants the bus to the controller |
| banks_open | input | 1 | At least one bank of the rank holds an open row |
| sleep_req | input | 1 | Request to enter a low-power state |
| sleep_sr | input | 1 | Low-power kind: 1 self refresh, 0 power-down |
| wake_req | input | 1 | Request to leave the low-power state |
| cke | output | NUM_CKE | Clock enables, one per device group |
| cmd | output | 2 | Command: 0 NOP, 1 precharge-all, 2 refresh |
| addr10 | output | 1 | Address bit 10, high with precharge-all |
| cmd_ok | output | 1 | Arbiter may issue non-read commands |
| rd_ok | output | 1 | Arbiter may issue reads |
| ref_force | output | 1 | Owed refreshes reached the limit; the arbiter must yield |

## Verification
The hardest situation to reach is a full refresh debt that has to be paid off. The bench gets there in two ways. First, it holds `arb_gnt` low for more than eight intervals, so the force path fires while the bus is taken. Second, it parks the rank in power-down without ever raising `wake_req`, so the debt fills and wakes the rank on its own, followed by a back-to-back burst of at least eight refreshes. The long read block after self refresh spans several refresh intervals. The bench therefore checks that refreshes issued during the block do not shift the cycle in which reads are allowed.

// File: rtl/sdram_rpm_pkg.sv
package sdram_rpm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_TRP, ST_REF, ST_TRFC,
        ST_SRE, ST_SR, ST_PD, ST_XP, ST_XSR
    } rpm_state_t;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REF  = 2'd2
    } rpm_cmd_t;
endpackage

// File: rtl/rpm_interval_timer.sv
module rpm_interval_timer #(
    parameter int REF_INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] tmr_q;

    assign tick = !hold && (tmr_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            tmr_q <= '0;
        else if (hold)         tmr_q <= '0;
        else if (tmr_q == LAST) tmr_q <= '0;
        else                   tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/rpm_debt_counter.sv
module rpm_debt_counter #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic full
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);

    logic [DW-1:0] debt_q;

    assign owed = (debt_q != '0);
    assign full = (debt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              debt_q <= '0;
        else if (clear)                          debt_q <= '0;
        else if (inc && !dec && debt_q != TOP)   debt_q <= debt_q + 1'b1;
        else if (dec && !inc && debt_q != '0)    debt_q <= debt_q - 1'b1;
    end
endmodule

// File: rtl/rpm_cke_lanes.sv
module rpm_cke_lanes #(
    parameter int NUM_CKE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_d,
    output logic [NUM_CKE-1:0] cke
);
    for (genvar g = 0; g < NUM_CKE; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cke[g] <= 1'b1;
            else        cke[g] <= en_d;
        end
    end
endmodule

// File: rtl/sdram_refresh_pm.sv
module sdram_refresh_pm
    import sdram_rpm_pkg::*;
#(
    parameter int REF_INTERVAL = 780,
    parameter int T_RFC        = 8,
    parameter int T_RP         = 2,
    parameter int T_XSNR       = 12,
    parameter int T_XSRD       = 200,
    parameter int T_XP         = 1,
    parameter int T_CKE        = 1,
    parameter int MAX_DEBT     = 8,
    parameter int NUM_CKE      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arb_gnt,
    input  logic               banks_open,
    input  logic               sleep_req,
    input  logic               sleep_sr,
    input  logic               wake_req,
    output logic [NUM_CKE-1:0] cke,
    output logic [1:0]         cmd,
    output logic               addr10,
    output logic               cmd_ok,
    output logic               rd_ok,
    output logic               ref_force
);
    localparam int T_A   = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int T_B   = (T_XSNR > T_XP) ? T_XSNR : T_XP;
    localparam int T_C   = (T_A > T_B) ? T_A : T_B;
    localparam int T_MAX = (T_C > T_CKE) ? T_C : T_CKE;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int RD_W  = $clog2(T_XSRD + 1);

    rpm_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [RD_W-1:0]   rdblk_q, rdblk_d;
    logic              goal_sr_q, goal_sr_d;
    logic              catch_q, catch_d;
    logic              tick, owed, full, in_sr, need_ref, cke_en_d;

    assign in_sr    = (state_q == ST_SRE) || (state_q == ST_SR);
    assign need_ref = owed && (arb_gnt || full || catch_q);
    assign cke_en_d = !((state_d == ST_SRE) || (state_d == ST_SR) || (state_d == ST_PD));

    rpm_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) i_timer (
        .clk(clk), .rst_n(rst_n), .hold(in_sr), .tick(tick)
    );

    rpm_debt_counter #(.MAX_DEBT(MAX_DEBT)) i_debt (
        .clk(clk), .rst_n(rst_n), .clear(in_sr), .inc(tick),
        .dec(state_q == ST_REF), .owed(owed), .full(full)
    );

    rpm_cke_lanes #(.NUM_CKE(NUM_CKE)) i_cke (
        .clk(clk), .rst_n(rst_n), .en_d(cke_en_d), .cke(cke)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            rdblk_q   <= '0;
            goal_sr_q <= 1'b0;
            catch_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            rdblk_q   <= rdblk_d;
            goal_sr_q <= goal_sr_d;
            catch_q   <= catch_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        rdblk_d   = (rdblk_q != '0) ? rdblk_q - 1'b1 : rdblk_q;
        goal_sr_d = goal_sr_q;
        catch_d   = catch_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!owed) catch_d = 1'b0;
                if (need_ref) begin
                    goal_sr_d = 1'b0;
                    state_d   = banks_open ? ST_PRE : ST_REF;
                end else if (sleep_req && arb_gnt) begin
                    if (sleep_sr) begin
                        goal_sr_d = 1'b1;
                        state_d   = banks_open ? ST_PRE : ST_SRE;
                    end else begin
                        state_d = ST_PD;
                        cnt_d   = CNT_W'(T_CKE - 1);
                    end
                end
            end
            ST_PRE: begin
                state_d = ST_TRP;
                cnt_d   = CNT_W'(T_RP - 2);
            end
            ST_TRP:
                if (cnt_q == '0) state_d = goal_sr_q ? ST_SRE : ST_REF;
            ST_REF: begin
                state_d = ST_TRFC;
                cnt_d   = CNT_W'(T_RFC - 2);
            end
            ST_TRFC:
                if (cnt_q == '0) state_d = (catch_q && owed) ? ST_REF : ST_IDLE;
            ST_SRE: begin
                state_d = ST_SR;
                cnt_d   = CNT_W'(T_CKE - 1);
            end
            ST_SR:
                if (cnt_q == '0 && wake_req) begin
                    state_d = ST_XSR;
                    cnt_d   = CNT_W'(T_XSNR - 1);
                    rdblk_d = RD_W'(T_XSRD);
                end
            ST_PD:
                if (cnt_q == '0 && (wake_req || full)) begin
                    state_d = ST_XP;
                    cnt_d   = CNT_W'(T_XP - 1);
                    catch_d = 1'b1;
                end
            ST_XP:
                if (cnt_q == '0) state_d = ST_IDLE;
            ST_XSR:
                if (cnt_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd       = CMD_NOP;
        addr10    = 1'b0;
        ref_force = full;
        cmd_ok    = (state_q == ST_IDLE) && !full && !(catch_q && owed);
        rd_ok     = cmd_ok && (rdblk_q == '0);
        unique case (state_q)
            ST_PRE: begin
                cmd    = CMD_PREA;
                addr10 = 1'b1;
            end
            ST_REF, ST_SRE: cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/rpm_checker.sv
module rpm_checker #(
    parameter int T_RFC   = 8,
    parameter int T_XSRD  = 200,
    parameter int NUM_CKE = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CKE-1:0] cke,
    input logic [1:0]         cmd,
    input logic               addr10,
    input logic               cmd_ok,
    input logic               rd_ok,
    input logic               ref_force
);
    logic [15:0] since_ref;
    logic        seen_ref;
    logic        sr_flag;
    logic        rd_block;
    logic [15:0] since_exit;
    logic        ref_hi;

    assign ref_hi = (cmd == 2'd2) && cke[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ref  <= '0;
            seen_ref   <= 1'b0;
            sr_flag    <= 1'b0;
            rd_block   <= 1'b0;
            since_exit <= '0;
        end else begin
            if (ref_hi) begin
                since_ref <= 16'd1;
                seen_ref  <= 1'b1;
            end else if (since_ref != 16'hFFFF) begin
                since_ref <= since_ref + 16'd1;
            end
            if (cmd == 2'd2 && !cke[0]) sr_flag <= 1'b1;
            if (sr_flag && cke[0]) begin
                sr_flag    <= 1'b0;
                rd_block   <= 1'b1;
                since_exit <= 16'd1;
            end else if (rd_block) begin
                if (since_exit >= 16'(T_XSRD)) rd_block <= 1'b0;
                else since_exit <= since_exit + 16'd1;
            end
        end
    end

    p_prea_a10_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> addr10);

    p_ref_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hi && seen_ref) |-> (since_ref >= 16'(T_RFC)));

    p_ref_holds_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hi |=> !cmd_ok);

    p_force_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_force |-> !cmd_ok);

    p_sre_stays_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2 && !cke[0]) |=> !cke[0]);

    p_read_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_block && since_exit < 16'(T_XSRD)) |-> !rd_ok);

    p_low_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke[0] && !$past(cke[0])) |-> (cmd == 2'd0));
endmodule

bind sdram_refresh_pm rpm_checker #(
    .T_RFC(T_RFC), .T_XSRD(T_XSRD), .NUM_CKE(NUM_CKE)
) i_rpm_checker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .addr10(addr10),
    .cmd_ok(cmd_ok), .rd_ok(rd_ok), .ref_force(ref_force)
);

// File: tb/test_sdram_refresh_pm.sv
module test_sdram_refresh_pm;
    localparam int RI    = 40;
    localparam int TRFC  = 8;
    localparam int TRP   = 3;
    localparam int TXSNR = 12;
    localparam int TXSRD = 200;
    localparam int TXP   = 2;
    localparam int TCKE  = 3;
    localparam int MAXD  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arb_gnt = 1'b0, banks_open = 1'b0, sleep_req = 1'b0, sleep_sr = 1'b0, wake_req = 1'b0;
    logic [1:0] cke;
    logic [1:0] cmd;
    logic addr10, cmd_ok, rd_ok, ref_force;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sdram_refresh_pm #(
        .REF_INTERVAL(RI), .T_RFC(TRFC), .T_RP(TRP), .T_XSNR(TXSNR),
        .T_XSRD(TXSRD), .T_XP(TXP), .T_CKE(TCKE), .MAX_DEBT(MAXD), .NUM_CKE(2)
    ) i_sdram_refresh_pm (
        .clk(clk), .rst_n(rst_n), .arb_gnt(arb_gnt), .banks_open(banks_open),
        .sleep_req(sleep_req), .sleep_sr(sleep_sr), .wake_req(wake_req),
        .cke(cke), .cmd(cmd), .addr10(addr10), .cmd_ok(cmd_ok),
        .rd_ok(rd_ok), .ref_force(ref_force)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Behavioural reference: phases as integers, stepped once per cycle.
    localparam int M_IDLE = 0, M_PRE = 1, M_TRP = 2, M_REF = 3, M_TRFC = 4;
    localparam int M_SRE = 5, M_SR = 6, M_PD = 7, M_XP = 8, M_XSR = 9;
    int m_ph = M_IDLE, m_wait = 0, m_debt = 0, m_tmr = 0, m_rd = 0;
    bit m_catch = 0, m_to_sr = 0;

    function automatic int exp_cke();
        return (m_ph == M_SRE || m_ph == M_SR || m_ph == M_PD) ? 0 : 3;
    endfunction
    function automatic int exp_cmd();
        if (m_ph == M_PRE) return 1;
        if (m_ph == M_REF || m_ph == M_SRE) return 2;
        return 0;
    endfunction
    function automatic bit exp_ok();
        return (m_ph == M_IDLE) && (m_debt != MAXD) && !(m_catch && m_debt != 0);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_ph = M_IDLE; m_wait = 0; m_debt = 0; m_tmr = 0; m_rd = 0;
            m_catch = 0; m_to_sr = 0;
        end else begin
            int nph, nwait, nrd;
            bit tick, asleep;
            chk(cke[0] == cke[1], "R11 cke lanes", cke[1], cke[0]);
            chk(int'(cke) == exp_cke(), "R6 R8 cke level", cke, exp_cke());
            chk(int'(cmd) == exp_cmd(), "R2 cmd", cmd, exp_cmd());
            chk(addr10 == (m_ph == M_PRE), "R3 addr10", addr10, m_ph == M_PRE);
            chk(cmd_ok == exp_ok(), "R4 cmd_ok", cmd_ok, exp_ok());
            chk(rd_ok == (exp_ok() && m_rd == 0), "R7 rd_ok", rd_ok, exp_ok() && m_rd == 0);
            chk(ref_force == (m_debt == MAXD), "R5 ref_force", ref_force, m_debt == MAXD);
            asleep = (m_ph == M_SRE || m_ph == M_SR);
            tick = !asleep && (m_tmr == RI - 1);
            nph = m_ph;
            nwait = (m_wait > 0) ? m_wait - 1 : 0;
            nrd = (m_rd > 0) ? m_rd - 1 : 0;
            case (m_ph)
                M_IDLE: begin
                    if (m_debt == 0) m_catch = 0;
                    if (m_debt != 0 && (arb_gnt || m_debt == MAXD || m_catch)) begin
                        m_to_sr = 0; nph = banks_open ? M_PRE : M_REF;
                    end else if (sleep_req && arb_gnt) begin
                        if (sleep_sr) begin m_to_sr = 1; nph = banks_open ? M_PRE : M_SRE; end
                        else begin nph = M_PD; nwait = TCKE - 1; end
                    end
                end
                M_PRE: begin nph = M_TRP; nwait = TRP - 2; end
                M_TRP: if (m_wait == 0) nph = m_to_sr ? M_SRE : M_REF;
                M_REF: begin nph = M_TRFC; nwait = TRFC - 2; end
                M_TRFC: if (m_wait == 0) nph = (m_catch && m_debt != 0) ? M_REF : M_IDLE;
                M_SRE: begin nph = M_SR; nwait = TCKE - 1; end
                M_SR: if (m_wait == 0 && wake_req) begin nph = M_XSR; nwait = TXSNR - 1; nrd = TXSRD; end
                M_PD: if (m_wait == 0 && (wake_req || m_debt == MAXD)) begin
                    nph = M_XP; nwait = TXP - 1; m_catch = 1;
                end
                M_XP: if (m_wait == 0) nph = M_IDLE;
                M_XSR: if (m_wait == 0) nph = M_IDLE;
                default: nph = M_IDLE;
            endcase
            if (asleep) begin m_tmr = 0; m_debt = 0; end
            else begin
                m_tmr = tick ? 0 : m_tmr + 1;
                m_debt = m_debt + (tick ? 1 : 0) - ((m_ph == M_REF) ? 1 : 0);
                if (m_debt > MAXD) m_debt = MAXD;
                if (m_debt < 0) m_debt = 0;
            end
            m_ph = nph; m_wait = nwait; m_rd = nrd;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic drive();
        @(posedge clk); #1;
    endtask

    task automatic wait_for(input int sel, input int limit, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if ((sel == 0 && cmd == 2'd2 && cke == 2'b11) || (sel == 1 && cmd == 2'd1) ||
                (sel == 2 && ref_force) || (sel == 3 && cke == 2'b00) ||
                (sel == 4 && cke == 2'b11) || (sel == 5 && cmd_ok)) return;
            n++;
            if (n >= limit) return;
        end
    endtask

    initial begin
        int n, k, nref, last, first_ref, ok_at, rd_at, bad;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cke == 2'b11 && cmd == 2'd0 && !addr10, "R1 reset pins", {cke, cmd, addr10}, 5'b11000);
        chk(cmd_ok && rd_ok && !ref_force, "R1 reset flags", {cmd_ok, rd_ok, ref_force}, 3'b110);

        drive(); arb_gnt = 1'b1;
        wait_for(0, 3 * RI, n);
        chk(n < RI + 4, "R2 first refresh issued", n, RI);
        wait_for(5, 100, n);
        chk(n + 1 == TRFC, "R4 cmd_ok after REF", n + 1, TRFC);

        drive(); banks_open = 1'b1;
        wait_for(1, 3 * RI, n);
        chk(addr10 == 1'b1, "R3 precharge-all addr10", addr10, 1);
        wait_for(0, 100, n);
        chk(n + 1 == TRP, "R3 REF after precharge", n + 1, TRP);
        drive(); banks_open = 1'b0;

        drive(); arb_gnt = 1'b0;
        wait_for(2, 12 * RI, n);
        chk(ref_force == 1'b1, "R5 force raised", ref_force, 1);
        chk(cmd_ok == 1'b0, "R5 cmd_ok low under force", cmd_ok, 0);
        @(negedge clk);
        chk(cmd == 2'd2, "R5 forced REF without grant", cmd, 2);
        drive(); arb_gnt = 1'b1;
        repeat (120) @(negedge clk);

        // Power-down and catch-up
        drive(); sleep_req = 1'b1; sleep_sr = 1'b0;
        wait_for(3, 200, n);
        chk(cmd == 2'd0, "R8 power-down entry is NOP", cmd, 0);
        drive(); sleep_req = 1'b0;
        repeat (130) @(negedge clk);
        chk(cke == 2'b00, "R9 still in power-down", cke, 0);
        drive(); wake_req = 1'b1;
        wait_for(4, 20, n);
        drive(); wake_req = 1'b0;
        k = 1; nref = 0; last = 0; bad = 0;
        while (k < 400) begin
            @(negedge clk);
            if (cmd_ok) break;
            if (cmd == 2'd2) begin
                if (nref == 0) chk(k == TXP + 1, "R8 first command after exit", k, TXP + 1);
                else if (k - last != TRFC) bad++;
                nref++; last = k;
            end
            k++;
        end
        chk(nref >= 3, "R9 owed refreshes replayed", nref, 3);
        chk(bad == 0, "R9 back-to-back spacing", bad, 0);

        // Power-down with no wake: debt limit wakes it
        repeat (5) @(negedge clk);
        drive(); sleep_req = 1'b1;
        wait_for(3, 200, n);
        drive(); sleep_req = 1'b0;
        wait_for(4, 12 * RI, n);
        chk(cke == 2'b11, "R10 auto wake on full debt", cke, 3);
        nref = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cmd_ok) break;
            if (cmd == 2'd2) nref++;
        end
        chk(nref >= MAXD, "R10 full debt repaid", nref, MAXD);

        // Self refresh with an open bank
        repeat (5) @(negedge clk);
        drive(); banks_open = 1'b1; sleep_sr = 1'b1; sleep_req = 1'b1;
        wait_for(1, 200, n);
        for (int i = 1; i <= TRP; i++) @(negedge clk);
        chk(cmd == 2'd2 && cke == 2'b00, "R6 self-refresh entry", {cmd, cke}, 4'b1000);
        drive(); sleep_req = 1'b0; banks_open = 1'b0;
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cke != 2'b00 || cmd != 2'd0) bad++;
        end
        chk(bad == 0, "R6 held in self refresh", bad, 0);
        drive(); wake_req = 1'b1;
        wait_for(4, 20, n);
        drive(); wake_req = 1'b0;
        first_ref = -1; ok_at = -1; rd_at = -1;
        for (int i = 1; i < 260; i++) begin
            @(negedge clk);
            if (first_ref < 0 && cmd == 2'd2) first_ref = i;
            if (ok_at < 0 && cmd_ok) ok_at = i;
            if (rd_at < 0 && rd_ok) rd_at = i;
        end
        chk(ok_at == TXSNR, "R7 non-read delay", ok_at, TXSNR);
        chk(rd_at == TXSRD, "R7 read delay", rd_at, TXSRD);
        chk(first_ref == RI + 1, "R12 no debt from self refresh", first_ref, RI + 1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule